// File: doc/BRIEF.md
# Edge-Interrupt Digital I/O Port

This block is an eight-pin general-purpose digital port on a simple word-wide register bus. The pins split into two groups of four, a low group (pins 0 to 3) and a high group (pins 4 to 7). Each group is switched between input and output as a whole by one bit in a 16-bit control word. The same word holds the output values that are driven on output pins. When it is read, its low byte returns the present level of every pin.

Every pin feeds a two-flop synchronizer and an edge detector. Each low-group pin has its own edge-polarity bit. The four high-group pins share one polarity bit. A detected edge sets a sticky status bit, whether or not that pin's interrupt is enabled. Software clears a status bit by writing 1 to it. The interrupt output is raised while any status bit is set together with its matching enable bit.

The bus has three registers at word addresses 0 (control), 1 (interrupt enable) and 2 (interrupt status). Address 3 reads as zero and ignores writes. Reads are combinational from the address. Writes take effect on the clock edge where the write strobe is high.

Top module: `edgeirq_gpio`

## Requirements
- R1: After a synchronous reset, all eight pins are inputs (`pin_oe` = 0). The enable and status registers read zero, and `irq` is low.
- R2: A write to address 0 updates the following on the next clock edge. Bits 7:0 drive `pin_out[7:0]`. Bit 10 set makes pins 0–3 outputs (`pin_oe[3:0]` all 1). Bit 11 set makes pins 4–7 outputs (`pin_oe[7:4]` all 1).
- R3: A read of address 0 returns the levels of `pin_in` in bits 7:0, after two synchronizer flops. A change applied before clock edge k is visible after edge k+1. Bits 15:10 and bit 8 return the values last written, and bit 9 always reads 0.
- R4: For pins 0–3, control bit 12+n selects the edge that sets status for pin n: 0 selects the rising edge and 1 the falling edge. The other edge of that pin sets nothing.
- R5: Control bit 8 selects one edge for all of pins 4–7, with the same encoding as R4 (0 rising, 1 falling).
- R6: The status bit for pin n is bit 8+n of address 2. After a qualifying edge applied before clock edge k, the bit reads 1 after edge k+2 and not earlier. It is set whether or not the matching enable bit is on.
- R7: A write to address 2 clears each status bit whose data bit is 1 and leaves the bits written 0 unchanged. If an edge and a clearing write reach the same bit on the same clock edge, the bit stays set.
- R8: Address 1 holds the interrupt enables in bits 15:8, where bit 8+n enables pin n. Bits 7:0 read 0. A write of 0xFFFF reads back as 0xFF00.
- R9: `irq` is high exactly when some status bit and its enable bit are both 1. It follows register changes without further delay.
- R10: Pin changes while reset is asserted produce no status bit after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 2 | Word address: 0 control, 1 enable, 2 status |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| pin_in | input | 8 | Pin levels from the pads |
| pin_out | output | 8 | Output values to the pads |
| pin_oe | output | 8 | Per-pin output enable, set per group of four |
| irq | output | 1 | Interrupt request |

## Verification
Each result has a fixed latency. Register writes appear one clock edge after the strobe. A pin change shows in the level readback two edges after it is applied, and in the status register three edges after it is applied. The interrupt line follows the status and enable registers with no extra delay. The bench applies every stimulus at a falling clock edge and samples at later falling edges, counted from that point. In the edge tests it checks both that the status bit is still clear on the edge before it is due and that it is set on the edge where it is due. The same-edge set and clear case is lined up so that the clearing write is captured on exactly the edge where the status bit sets.

// File: rtl/edgeirq_pkg.sv
package edgeirq_pkg;

    localparam int NPINS  = 8;
    localparam int GRP_W  = 4;
    localparam int DATA_W = 16;
    localparam int ADDR_W = 2;
    localparam int IRQ_LSB = 8;

    typedef enum logic [ADDR_W-1:0] {
        SEL_CTRL  = 2'd0,
        SEL_IEN   = 2'd1,
        SEL_ISTAT = 2'd2,
        SEL_NONE  = 2'd3
    } reg_sel_e;

    // Control word layout (bit positions are part of the interface)
    typedef struct packed {
        logic [GRP_W-1:0] lo_fall;  // 15:12 per-pin edge select, pins 0..3
        logic             hi_oe;    // 11
        logic             lo_oe;    // 10
        logic             rsvd;     // 9
        logic             hi_fall;  // 8 shared edge select, pins 4..7
        logic [NPINS-1:0] out_val;  // 7:0
    } ctrl_t;

    function automatic logic [NPINS-1:0] fall_select(ctrl_t c);
        return {{GRP_W{c.hi_fall}}, c.lo_fall};
    endfunction

    function automatic logic [NPINS-1:0] oe_expand(ctrl_t c);
        return {{GRP_W{c.hi_oe}}, {GRP_W{c.lo_oe}}};
    endfunction

endpackage

// File: rtl/edgeirq_sync.sv
module edgeirq_sync
    import edgeirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NPINS-1:0] pin_in,
    input  logic [NPINS-1:0] fall_sel,
    output logic [NPINS-1:0] level,
    output logic [NPINS-1:0] edge_ev
);

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic meta_q, sync_q, prev_q;

        // During reset all stages load the pin, so no edge is seen on release
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= pin_in[i];
                sync_q <= pin_in[i];
                prev_q <= pin_in[i];
            end else begin
                meta_q <= pin_in[i];
                sync_q <= meta_q;
                prev_q <= sync_q;
            end
        end

        assign level[i]   = sync_q;
        assign edge_ev[i] = fall_sel[i] ? (prev_q & ~sync_q) : (sync_q & ~prev_q);
    end

    AST_QUIET_AFTER_RESET: assert property (@(posedge clk)
        rst |=> (edge_ev == '0)); // R10

endmodule

// File: rtl/edgeirq_ctrl.sv
module edgeirq_ctrl
    import edgeirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_ctrl,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl
);

    ctrl_t ctrl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q      <= ctrl_t'(wdata);
            ctrl_q.rsvd <= 1'b0;
        end
    end

    assign ctrl = ctrl_q;

    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (ctrl_q.rsvd == 1'b0)); // R3

endmodule

// File: rtl/edgeirq_status.sv
module edgeirq_status
    import edgeirq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_ien,
    input  logic             wr_clr,
    input  logic [NPINS-1:0] wbits,
    input  logic [NPINS-1:0] edge_ev,
    output logic [NPINS-1:0] ien,
    output logic [NPINS-1:0] istat
);

    logic [NPINS-1:0] clr_mask;
    assign clr_mask = wr_clr ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ien   <= '0;
            istat <= '0;
        end else begin
            if (wr_ien)
                ien <= wbits;
            // a new edge wins over a clearing write on the same cycle
            istat <= (istat & ~clr_mask) | edge_ev;
        end
    end

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (rst)
            (istat[i] && !clr_mask[i]) |=> istat[i]); // R7
        AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
            (!istat[i] && !edge_ev[i]) |=> !istat[i]); // R6
        AST_EDGE_SETS: assert property (@(posedge clk) disable iff (rst)
            edge_ev[i] |=> istat[i]); // R7
    end

endmodule

// File: rtl/edgeirq_gpio.sv
module edgeirq_gpio
    import edgeirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic              irq
);

    reg_sel_e         sel;
    ctrl_t            ctrl;
    logic [NPINS-1:0] level, edge_ev, ien, istat;
    logic             wr_ctrl, wr_ien, wr_clr;

    assign sel     = reg_sel_e'(bus_addr);
    assign wr_ctrl = bus_wr && (sel == SEL_CTRL);
    assign wr_ien  = bus_wr && (sel == SEL_IEN);
    assign wr_clr  = bus_wr && (sel == SEL_ISTAT);

    edgeirq_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .wr_ctrl (wr_ctrl),
        .wdata   (bus_wdata),
        .ctrl    (ctrl)
    );

    edgeirq_sync u_sync (
        .clk      (clk),
        .rst      (rst),
        .pin_in   (pin_in),
        .fall_sel (fall_select(ctrl)),
        .level    (level),
        .edge_ev  (edge_ev)
    );

    edgeirq_status u_status (
        .clk     (clk),
        .rst     (rst),
        .wr_ien  (wr_ien),
        .wr_clr  (wr_clr),
        .wbits   (bus_wdata[IRQ_LSB +: NPINS]),
        .edge_ev (edge_ev),
        .ien     (ien),
        .istat   (istat)
    );

    assign pin_out = ctrl.out_val;
    assign pin_oe  = oe_expand(ctrl);
    assign irq     = |(istat & ien);

    always_comb begin
        unique case (sel)
            SEL_CTRL:  bus_rdata = {ctrl[DATA_W-1:NPINS], level};
            SEL_IEN:   bus_rdata = {ien, {NPINS{1'b0}}};
            SEL_ISTAT: bus_rdata = {istat, {NPINS{1'b0}}};
            default:   bus_rdata = '0;
        endcase
    end

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pin_oe == '0 && !irq)); // R1
    AST_OE_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        wr_ctrl |=> (pin_oe[0] == $past(bus_wdata[10]) &&
                     pin_oe[NPINS-1] == $past(bus_wdata[11]))); // R2
    AST_IRQ_RAISED: assert property (@(posedge clk) disable iff (rst)
        ((|(edge_ev & ien)) && !wr_ien) |=> irq); // R9

endmodule

// File: tb/edgeirq_gpio_tb.sv
module edgeirq_gpio_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  pin_in = '0;
    logic [7:0]  pin_out, pin_oe;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    edgeirq_gpio u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // called at a falling edge; returns at the next falling edge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk("R1 oe", {8'h0, pin_oe}, 16'h0);
        chk("R1 irq", {15'h0, irq}, 16'h0);
        rd(1, d); chk("R1 ien", d, 16'h0);
        rd(2, d); chk("R1 status", d, 16'h0);

        // R2 outputs and group enables
        wr(0, 16'h04A5);
        chk("R2 out", {8'h0, pin_out}, 16'h00A5);
        chk("R2 oe low group", {8'h0, pin_oe}, 16'h000F);
        wr(0, 16'h085A);
        chk("R2 oe high group", {8'h0, pin_oe}, 16'h00F0);
        chk("R2 out2", {8'h0, pin_out}, 16'h005A);
        // R3 control readback, bit 9 reads 0
        wr(0, 16'hFF00);
        rd(0, d); chk("R3 high byte", d, 16'hFD00);
        chk("R2 oe both", {8'h0, pin_oe}, 16'h00FF);
        wr(0, 16'h0000);

        // R8 enable register readback
        wr(1, 16'hFFFF);
        rd(1, d); chk("R8 ien", d, 16'hFF00);
        wr(1, 16'h0000);

        // R3/R4/R5/R6 sweep: every pin, both polarities, both directions
        for (int n = 0; n < 8; n++) begin
            for (int pol = 0; pol < 2; pol++) begin
                logic [15:0] cw;
                logic [15:0] bit_n;
                cw = (n < 4) ? 16'(pol) << (12 + n) : 16'(pol) << 8;
                bit_n = 16'h1 << (8 + n);
                wr(0, cw);
                wr(2, 16'hFF00);
                // rising edge
                pin_in[n] = 1'b1;
                @(negedge clk); @(negedge clk);
                rd(0, d); chk("R3 level", {8'h0, d[7:0]}, 16'h1 << n);
                rd(2, d); chk("R6 not early", d, 16'h0);
                @(negedge clk);
                rd(2, d);
                chk((n < 4) ? "R4 rise" : "R5 rise", d, (pol == 0) ? bit_n : 16'h0);
                chk("R6 irq masked", {15'h0, irq}, 16'h0);
                wr(2, 16'hFF00);
                // falling edge
                pin_in[n] = 1'b0;
                repeat (3) @(negedge clk);
                rd(2, d);
                chk((n < 4) ? "R4 fall" : "R5 fall", d, (pol == 1) ? bit_n : 16'h0);
                wr(2, 16'hFF00);
            end
        end

        // R9 interrupt gating, R7 write-zero and write-one behaviour
        wr(0, 16'h0000);
        wr(1, 16'h2000);                 // enable pin 5 only
        pin_in[2] = 1'b1;
        repeat (3) @(negedge clk);
        rd(2, d); chk("R6 set while disabled", d, 16'h0400);
        chk("R9 irq off when disabled", {15'h0, irq}, 16'h0);
        wr(1, 16'h0400);
        chk("R9 irq on", {15'h0, irq}, 16'h1);
        wr(2, 16'hFB00);                 // zero on the set bit
        rd(2, d); chk("R7 write zero keeps", d, 16'h0400);
        wr(2, 16'h0400);
        rd(2, d); chk("R7 write one clears", d, 16'h0);
        chk("R9 irq off after clear", {15'h0, irq}, 16'h0);

        // R7 set wins over same-edge clear (pin 0 rise)
        pin_in[0] = 1'b1;
        @(negedge clk); @(negedge clk);
        wr(2, 16'h0100);
        rd(2, d); chk("R7 set wins", d, 16'h0100);
        wr(2, 16'h0100);
        rd(2, d); chk("R7 cleared after", d, 16'h0);

        // R10 pin changes during reset
        rst = 1'b1;
        @(negedge clk);
        pin_in = 8'hF0;
        @(negedge clk);
        pin_in = 8'h0F;
        @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        rd(2, d); chk("R10 no event", d, 16'h0);
        rd(0, d); chk("R10 level", {8'h0, d[7:0]}, 16'h000F);
        chk("R1 oe after reset", {8'h0, pin_oe}, 16'h0);

        finish_run();
    end

endmodule